// File: doc/BRIEF.md
# Memory board address select decoder

This block sits on one memory board and watches a shared 16-bit address/data bus. When the memory-start strobe is high at a rising clock edge, every board samples the bus word at that same edge. This decoder then decides whether its own board is addressed. The word is split into a module field, a column field, a row field and, depending on board capacity, a bank field and a board field. The board field is compared against an inclusive range set on two configuration inputs, which stand in for jumper settings. On a match, the decoder turns the module field into a one-hot select of modules A to D and presents the bank index and the row and column addresses.

The parameter `CAPACITY` picks the board size: 32K, 64K, 128K or 256K bytes. The 256K board is assumed to be the only board in the system, so it has no board field and answers every strobe. The 128K and 32K boards have no bank field and always report bank 0.

The result is produced one cycle after the strobe by a three-state machine:
- `ST_IDLE`: no decode result.
- `ST_HIT`: the board is addressed.
- `ST_MISS`: a strobe was seen but the board is not addressed.

From any state, a strobe at an edge moves the machine to `ST_HIT` if the sampled word matches and to `ST_MISS` if it does not. With no strobe, the machine returns to `ST_IDLE`. Each result therefore lasts exactly one cycle unless another strobe follows.

Top module: `mem_board_sel`

## Requirements
- R1: While reset is asserted, and after reset until the first strobe, `dec_done`, `board_hit`, `mod_sel`, `bank_idx`, `row_addr` and `col_addr` are all zero.
- R2: A strobe at rising edge k makes `dec_done` high during the cycle after edge k. With no strobe at edge k, `dec_done` is low during that cycle.
- R3: On a hit, `mod_sel` is one-hot, with bit index equal to bus bits [1:0] (0=A, 1=B, 2=C, 3=D).
- R4: On a hit, `col_addr` equals bus bits [7:2] for every capacity.
- R5: On a hit, `row_addr` equals bus bits [13:8] for the 256K and 128K boards. For the 64K and 32K boards it equals bus bits [12:8], zero-extended to 6 bits.
- R6: The board field is bus bits [15:14] for the 128K and 64K boards, zero-extended to 3 bits, and bus bits [15:13] for the 32K board. The board is hit only when `range_lo` ≤ field ≤ `range_hi`, unsigned and with both ends inclusive.
- R7: The 256K board hits on every strobe, whatever the board bits and the range inputs are.
- R8: `bank_idx` is bus bits [15:14] on the 256K board and bus bit 13, zero-extended, on the 64K board. It is always 0 on the 128K and 32K boards.
- R9: On a miss, `dec_done` is 1 while `board_hit`, `mod_sel`, `bank_idx`, `row_addr` and `col_addr` are all 0.
- R10: Strobes on consecutive edges are each decoded with their own word and range, and appear on consecutive result cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_start | input | 1 | Memory-start strobe; bus word sampled when high |
| bus_word | input | 16 | Shared address/data bus word |
| range_lo | input | 3 | Lowest board-field value this board answers |
| range_hi | input | 3 | Highest board-field value this board answers |
| dec_done | output | 1 | A decode result is presented this cycle |
| board_hit | output | 1 | This board is addressed |
| mod_sel | output | 4 | One-hot module select, bit 0 = A to bit 3 = D |
| bank_idx | output | 2 | Selected bank |
| row_addr | output | 6 | Row address for the selected module |
| col_addr | output | 6 | Column address for the selected module |

## Verification
Four boards, one of each capacity, share the same bus, and each strobe is checked against all four at once. The same word therefore shows whether each field is cut at the right bits for every size. Board values exactly at the low bound, exactly at the high bound, with both bounds equal, and one step outside each bound separate an inclusive comparison from an exclusive or off-by-one one. These words also separate the 256K board, which hits with a range that excludes everything, from the ranged boards. Words with each module code and with set bank and row bits show the one-hot mapping and the bank rules. Back-to-back strobes with idle gaps between groups show the one-cycle result timing and the return to `ST_IDLE`.

// File: rtl/mem_board_sel_pkg.sv
package mem_board_sel_pkg;

    typedef enum logic [1:0] {
        CAP_32K  = 2'd0,
        CAP_64K  = 2'd1,
        CAP_128K = 2'd2,
        CAP_256K = 2'd3
    } cap_e;

    localparam int WORD_W  = 16;
    localparam int MOD_W   = 2;
    localparam int NUM_MOD = 1 << MOD_W;
    localparam int COL_W   = 6;
    localparam int ROW_MAX = 6;
    localparam int BANK_MAX = 2;
    localparam int BOARD_MAX = 3;

    typedef logic [ROW_MAX-1:0]   row_t;
    typedef logic [COL_W-1:0]     col_t;
    typedef logic [BANK_MAX-1:0]  bank_t;
    typedef logic [BOARD_MAX-1:0] board_t;

    function automatic int row_width(cap_e c);
        return (c == CAP_256K || c == CAP_128K) ? 6 : 5;
    endfunction

    function automatic int bank_width(cap_e c);
        case (c)
            CAP_256K: return 2;
            CAP_64K:  return 1;
            default:  return 0;
        endcase
    endfunction

    function automatic int board_width(cap_e c);
        return WORD_W - MOD_W - COL_W - row_width(c) - bank_width(c);
    endfunction

endpackage

// File: rtl/mem_field_split.sv
module mem_field_split
    import mem_board_sel_pkg::*;
#(
    parameter cap_e CAPACITY = CAP_64K
) (
    input  logic [WORD_W-1:0] word,
    output logic [MOD_W-1:0]  mod_f,
    output col_t              col_f,
    output row_t              row_f,
    output bank_t             bank_f,
    output board_t            board_f
);
    localparam int ROW_W    = row_width(CAPACITY);
    localparam int BANK_W   = bank_width(CAPACITY);
    localparam int BOARD_W  = board_width(CAPACITY);
    localparam int COL_LSB  = MOD_W;
    localparam int ROW_LSB  = COL_LSB + COL_W;
    localparam int BANK_LSB = ROW_LSB + ROW_W;
    localparam int BRD_LSB  = BANK_LSB + BANK_W;

    assign mod_f = word[MOD_W-1:0];
    assign col_f = word[COL_LSB +: COL_W];

    logic [ROW_W-1:0] row_raw;
    assign row_raw = word[ROW_LSB +: ROW_W];
    assign row_f   = row_t'(row_raw);

    generate
        if (BANK_W > 0) begin : g_bank
            logic [BANK_W-1:0] bank_raw;
            assign bank_raw = word[BANK_LSB +: BANK_W];
            assign bank_f   = bank_t'(bank_raw);
        end else begin : g_no_bank
            assign bank_f = '0;
        end

        if (BOARD_W > 0) begin : g_board
            logic [BOARD_W-1:0] board_raw;
            assign board_raw = word[BRD_LSB +: BOARD_W];
            assign board_f   = board_t'(board_raw);
        end else begin : g_no_board
            assign board_f = '0;
        end
    endgenerate

endmodule

// File: rtl/mem_range_match.sv
module mem_range_match
    import mem_board_sel_pkg::*;
#(
    parameter int BOARD_W = 2
) (
    input  board_t board_f,
    input  board_t lo,
    input  board_t hi,
    output logic   match
);
    generate
        if (BOARD_W == 0) begin : g_sole_board
            assign match = 1'b1;
        end else begin : g_ranged
            assign match = (board_f >= lo) && (board_f <= hi);
        end
    endgenerate
endmodule

// File: rtl/mem_mod_onehot.sv
module mem_mod_onehot
    import mem_board_sel_pkg::*;
(
    input  logic               en,
    input  logic [MOD_W-1:0]   mod_f,
    output logic [NUM_MOD-1:0] sel
);
    generate
        for (genvar i = 0; i < NUM_MOD; i++) begin : g_sel
            assign sel[i] = en && (mod_f == MOD_W'(i));
        end
    endgenerate
endmodule

// File: rtl/mem_board_sel.sv
module mem_board_sel
    import mem_board_sel_pkg::*;
#(
    parameter cap_e CAPACITY = CAP_64K
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mem_start,
    input  logic [WORD_W-1:0]  bus_word,
    input  logic [2:0]         range_lo,
    input  logic [2:0]         range_hi,
    output logic               dec_done,
    output logic               board_hit,
    output logic [NUM_MOD-1:0] mod_sel,
    output logic [1:0]         bank_idx,
    output logic [5:0]         row_addr,
    output logic [5:0]         col_addr
);
    localparam int BOARD_W = board_width(CAPACITY);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } state_e;

    state_e state_q, state_d;

    logic [MOD_W-1:0] mod_f, mod_q;
    col_t             col_f, col_q;
    row_t             row_f, row_q;
    bank_t            bank_f, bank_q;
    board_t           board_f;
    logic             match;
    logic             hit_now;
    logic [NUM_MOD-1:0] sel_w;

    mem_field_split #(.CAPACITY(CAPACITY)) u_split (
        .word    (bus_word),
        .mod_f   (mod_f),
        .col_f   (col_f),
        .row_f   (row_f),
        .bank_f  (bank_f),
        .board_f (board_f)
    );

    mem_range_match #(.BOARD_W(BOARD_W)) u_match (
        .board_f (board_f),
        .lo      (range_lo),
        .hi      (range_hi),
        .match   (match)
    );

    always_comb begin
        state_d = ST_IDLE;
        if (mem_start) begin
            state_d = match ? ST_HIT : ST_MISS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q  <= '0;
            col_q  <= '0;
            row_q  <= '0;
            bank_q <= '0;
        end else if (mem_start) begin
            mod_q  <= mod_f;
            col_q  <= col_f;
            row_q  <= row_f;
            bank_q <= bank_f;
        end
    end

    assign hit_now = (state_q == ST_HIT);

    mem_mod_onehot u_onehot (
        .en    (hit_now),
        .mod_f (mod_q),
        .sel   (sel_w)
    );

    always_comb begin
        dec_done  = 1'b0;
        board_hit = 1'b0;
        mod_sel   = '0;
        bank_idx  = '0;
        row_addr  = '0;
        col_addr  = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_HIT: begin
                dec_done  = 1'b1;
                board_hit = 1'b1;
                mod_sel   = sel_w;
                bank_idx  = bank_q;
                row_addr  = row_q;
                col_addr  = col_q;
            end
            ST_MISS: begin
                dec_done = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/mem_board_sel_chk.sv
module mem_board_sel_chk
    import mem_board_sel_pkg::*;
#(
    parameter cap_e CAPACITY = CAP_64K
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_start,
    input logic [15:0] bus_word,
    input logic        dec_done,
    input logic        board_hit,
    input logic [3:0]  mod_sel,
    input logic [1:0]  bank_idx,
    input logic [5:0]  row_addr,
    input logic [5:0]  col_addr
);
    // R2
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |=> dec_done);

    // R2
    no_done_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_start |=> !dec_done);

    // R3
    onehot_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        board_hit |-> ($countones(mod_sel) == 1));

    // R4
    col_follows_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |=> (!board_hit || col_addr == $past(bus_word[7:2])));

    // R9
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && !board_hit) |-> (mod_sel == 4'd0 && bank_idx == 2'd0 &&
                                       row_addr == 6'd0 && col_addr == 6'd0));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_done |-> (!board_hit && mod_sel == 4'd0));

    // R7
    sole_board_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_start && CAPACITY == CAP_256K) |=> board_hit);
endmodule

bind mem_board_sel mem_board_sel_chk #(.CAPACITY(CAPACITY)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_start (mem_start),
    .bus_word  (bus_word),
    .dec_done  (dec_done),
    .board_hit (board_hit),
    .mod_sel   (mod_sel),
    .bank_idx  (bank_idx),
    .row_addr  (row_addr),
    .col_addr  (col_addr)
);

// File: tb/mem_board_sel_tb_top.sv
`timescale 1ns/1ps
module mem_board_sel_tb_top;
    import mem_board_sel_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_start = 1'b0;
    logic [15:0] bus_word = '0;
    logic [2:0]  range_lo = '0;
    logic [2:0]  range_hi = '0;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    logic [19:0] got [4];

    for (genvar g = 0; g < 4; g++) begin : g_dut
        logic       d_done, d_hit;
        logic [3:0] d_sel;
        logic [1:0] d_bank;
        logic [5:0] d_row, d_col;
        if (g == 1) begin : g_main
            mem_board_sel #(.CAPACITY(CAP_64K)) dut_i (
                .clk(clk), .rst_n(rst_n), .mem_start(mem_start), .bus_word(bus_word),
                .range_lo(range_lo), .range_hi(range_hi), .dec_done(d_done),
                .board_hit(d_hit), .mod_sel(d_sel), .bank_idx(d_bank),
                .row_addr(d_row), .col_addr(d_col));
        end else begin : g_other
            mem_board_sel #(.CAPACITY(cap_e'(g))) dut_o (
                .clk(clk), .rst_n(rst_n), .mem_start(mem_start), .bus_word(bus_word),
                .range_lo(range_lo), .range_hi(range_hi), .dec_done(d_done),
                .board_hit(d_hit), .mod_sel(d_sel), .bank_idx(d_bank),
                .row_addr(d_row), .col_addr(d_col));
        end
        assign got[g] = {d_done, d_hit, d_sel, d_bank, d_row, d_col};
    end

    // Expected result from the requirement encodings; cap 0=32K 1=64K 2=128K 3=256K
    function automatic logic [19:0] model(int cap, logic st, logic [15:0] w,
                                          logic [2:0] lo, logic [2:0] hi);
        logic [5:0] row, col;
        logic [2:0] brd;
        logic [1:0] bank;
        logic       hit;
        if (!st) return 20'd0;                                   // R2
        col  = w[7:2];                                           // R4
        row  = (cap >= 2) ? w[13:8] : {1'b0, w[12:8]};           // R5
        brd  = (cap == 0) ? w[15:13] : {1'b0, w[15:14]};         // R6
        bank = (cap == 3) ? w[15:14] : (cap == 1) ? {1'b0, w[13]} : 2'd0; // R8
        hit  = (cap == 3) || (brd >= lo && brd <= hi);           // R6 R7
        if (!hit) return {1'b1, 19'd0};                          // R9
        return {1'b1, 1'b1, 4'b0001 << w[1:0], bank, row, col};  // R3
    endfunction

    typedef struct {
        int          t;
        logic [79:0] e;
        string       tag;
    } item_t;
    item_t sb_q[$];

    task automatic drive(input logic st, input logic [15:0] w, input logic [2:0] lo,
                         input logic [2:0] hi, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        mem_start = st;
        bus_word  = w;
        range_lo  = lo;
        range_hi  = hi;
        it.t   = cyc + 1;
        it.tag = tag;
        for (int c = 0; c < 4; c++) it.e[c*20 +: 20] = model(c, st, w, lo, hi);
        sb_q.push_back(it);
    endtask

    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].t <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            for (int c = 0; c < 4; c++) begin
                n_checks++;
                if (got[c] !== it.e[c*20 +: 20]) begin
                    n_fail++;
                    $display("FAIL %s board%0d got %h exp %h", it.tag, c, got[c],
                             it.e[c*20 +: 20]);
                end
            end
        end
    end

    task automatic check_zero(input string tag);
        for (int c = 0; c < 4; c++) begin
            n_checks++;
            if (got[c] !== 20'd0) begin
                n_fail++;
                $display("FAIL %s board%0d got %h exp %h", tag, c, got[c], 20'd0);
            end
        end
    endtask

    initial begin
        #1000000;
        if (!done_flag) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog got hang exp finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_zero("R1 in reset");
        @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_zero("R1 after reset");

        // module codes, range 1..2 for ranged boards
        drive(1'b1, 16'b01_1_10110_101101_00, 3'd1, 3'd2, "R3 mod A");
        drive(1'b1, 16'b01_0_11111_000001_01, 3'd1, 3'd2, "R3 mod B R10");
        drive(1'b1, 16'b10_1_00001_111111_10, 3'd1, 3'd2, "R3 mod C R5");
        drive(1'b1, 16'b10_0_10101_010101_11, 3'd1, 3'd2, "R3 mod D R8");
        drive(1'b0, 16'hFFFF, 3'd1, 3'd2, "R2 idle");
        // range boundaries
        drive(1'b1, 16'b00_1_11001_100110_01, 3'd1, 3'd2, "R6 below lo R7 R9");
        drive(1'b1, 16'b11_1_01010_011001_10, 3'd1, 3'd2, "R6 above hi R8");
        drive(1'b0, 16'h0000, 3'd0, 3'd0, "R2 idle");
        drive(1'b1, 16'b11_0_00011_001100_11, 3'd3, 3'd3, "R6 lo eq hi");
        drive(1'b1, 16'b11_1_11100_110011_00, 3'd3, 3'd3, "R6 32K field 7");
        drive(1'b1, 16'b01_0_01110_101010_10, 3'd3, 3'd1, "R7 empty range");
        drive(1'b1, 16'b00_0_00000_000000_00, 3'd0, 3'd7, "R6 full range zero word");
        drive(1'b1, 16'hFFFF, 3'd0, 3'd7, "R8 R5 all ones");
        drive(1'b1, 16'b00_1_00000_000000_11, 3'd1, 3'd3, "R6 32K field 1");
        drive(1'b0, 16'h5A5A, 3'd0, 3'd7, "R2 no strobe");
        drive(1'b0, 16'h0000, 3'd0, 3'd7, "R2 idle");
        for (int k = 0; k < 24; k++) begin
            drive(1'b1, 16'((k * 16'h2F3B) ^ 16'h91C4), 3'(k % 5), 3'((k % 5) + (k % 3)),
                  "R10 sweep");
            if (k % 6 == 5) drive(1'b0, 16'h0000, 3'd0, 3'd0, "R2 gap");
        end
        drive(1'b0, 16'h0000, 3'd0, 3'd0, "R2 tail");
        repeat (3) @(negedge clk);
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule